// File: doc/BRIEF.md
# Cache Mode Sequencer with Retention Recovery

This controller sets the operating mode of an instruction cache whose data array can also serve as general-purpose RAM (the split mode). Software presents a requested mode on a one-cycle request strobe. The block either switches at once, rejects the request with a one-cycle error pulse, or runs an initialisation sweep first. The sweep writes an invalid entry into every index of the tag store, one index per cycle. The current mode and a busy flag are visible at all times. The tag store is reached only through the clear strobe and address.

The block keeps one internal flag that says whether the tags are valid. The flag is clear after reset. A completed sweep sets it. A retention power-down taken in split mode clears it, because the RAM contents survive retention but the tags do not. While the flag is clear, a direct switch into the enabled mode is refused. To recover, software requests OFF and then requests ENABLED, which runs a fresh sweep. Software may also go from OFF to DISABLED directly.

Mode code values on `req_mode_i` and `mode_o` are OFF=0, DISABLED=1, ENABLED=2 and SPLIT=3. A request or retention pulse sampled at clock edge k takes effect in the outputs right after edge k.

Top module: `cmode_seq`

## Requirements
- R1: After reset, `mode_o` is OFF (0) and `busy_o`, `tag_we_o` and `err_o` are all low.
- R2: The following legal switches take effect one cycle after the request, without a sweep: OFF from any mode, DISABLED (1) from OFF, from ENABLED or from SPLIT.
- R3: A request for ENABLED (2) or SPLIT (3) made from OFF starts a sweep. `busy_o` is high for exactly TAGS cycles and `mode_o` reads OFF during those cycles. After that, `mode_o` shows the requested mode.
- R4: During the sweep, `tag_we_o` is high in every busy cycle and in no other cycle. `tag_addr_o` goes through 0, 1, ..., TAGS-1, one value per cycle.
- R5: While `busy_o` is high, requests and retention pulses are ignored. They do not change the sweep, its target or the error flag.
- R6: Requesting SPLIT from DISABLED or from ENABLED is illegal. An illegal request leaves `mode_o` unchanged and raises `err_o` for exactly the one cycle after the request.
- R7: Requesting ENABLED from DISABLED or from SPLIT is legal only while the tags are valid, and then it takes effect in one cycle. The tags are valid after a completed sweep and stay valid until a retention event. Otherwise the request is illegal, as in R6.
- R8: A retention pulse (`ret_i`) taken in SPLIT keeps `mode_o` at SPLIT, gives no error, and marks the tags invalid. A retention pulse in any other mode is illegal: it raises `err_o` and has no other effect.
- R9: After a retention event, ENABLED can be reached only through OFF. The sweep started from OFF then runs in full, reaches ENABLED, and makes the tags valid again.
- R10: A request for the mode already in force does nothing and gives no error. When `ret_i` and `req_valid_i` are both high in the same cycle, the retention pulse is handled and the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle mode request strobe |
| req_mode_i | input | 2 | Requested mode code |
| ret_i | input | 1 | Retention power-down event pulse |
| mode_o | output | 2 | Current mode code |
| busy_o | output | 1 | High while the tag sweep runs |
| tag_we_o | output | 1 | Tag-clear write strobe |
| tag_addr_o | output | $clog2(TAGS) | Tag index being cleared |
| err_o | output | 1 | One-cycle pulse on an illegal request or retention |

## Verification
The bench builds the block with TAGS=6. This keeps each sweep to six cycles, so random stimulus over a few thousand cycles passes through many sweeps, retentions and recoveries. Six is also not a power of two, so the address counter has to stop at the last index before it would wrap naturally. The directed steps go through the whole retention-recovery path and the priority of retention over a request in the same cycle.

// File: rtl/cmode_pkg.sv
package cmode_pkg;
  typedef enum logic [1:0] {
    M_OFF   = 2'd0,
    M_DIS   = 2'd1,
    M_EN    = 2'd2,
    M_SPLIT = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    A_NOP  = 2'd0,
    A_GO   = 2'd1,
    A_INIT = 2'd2,
    A_ERR  = 2'd3
  } act_e;
endpackage

// File: rtl/cmode_rules.sv
module cmode_rules
  import cmode_pkg::*;
(
  input  mode_e cur_i,
  input  mode_e req_i,
  input  logic  tags_ok_i,
  output act_e  act_o
);
  always_comb begin
    act_o = A_ERR;
    if (req_i == cur_i) begin
      act_o = A_NOP;
    end else if (req_i == M_OFF) begin
      act_o = A_GO;
    end else begin
      unique case (cur_i)
        M_OFF:   act_o = (req_i == M_DIS) ? A_GO : A_INIT;
        M_DIS:   act_o = (req_i == M_EN && tags_ok_i) ? A_GO : A_ERR;
        M_EN:    act_o = (req_i == M_DIS) ? A_GO : A_ERR;
        M_SPLIT: begin
          if (req_i == M_DIS)                 act_o = A_GO;
          else if (req_i == M_EN && tags_ok_i) act_o = A_GO;
          else                                 act_o = A_ERR;
        end
        default: act_o = A_ERR;
      endcase
    end
  end
endmodule

// File: rtl/cmode_sweep.sv
module cmode_sweep #(
  parameter int TAGS = 64,
  localparam int AW = $clog2(TAGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          active_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] LAST = AW'(TAGS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      addr_o   <= '0;
    end else if (active_o) begin
      if (addr_o == LAST) active_o <= 1'b0;
      else                addr_o   <= addr_o + AW'(1);
    end else if (start_i) begin
      active_o <= 1'b1;
      addr_o   <= '0;
    end
  end

  assign done_o = active_o && (addr_o == LAST);

  // R4
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (int'(addr_o) < TAGS));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o)) |-> (addr_o == $past(addr_o) + AW'(1)));
endmodule

// File: rtl/cmode_seq.sv
module cmode_seq
  import cmode_pkg::*;
#(
  parameter int TAGS = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid_i,
  input  logic [1:0]              req_mode_i,
  input  logic                    ret_i,
  output logic [1:0]              mode_o,
  output logic                    busy_o,
  output logic                    tag_we_o,
  output logic [$clog2(TAGS)-1:0] tag_addr_o,
  output logic                    err_o
);
  localparam int AW = $clog2(TAGS);

  mode_e cur_q, tgt_q, req_m;
  logic  tags_ok_q, err_q, sweep_on, sweep_done, start;
  act_e  act;

  assign req_m = mode_e'(req_mode_i);

  cmode_rules rules_i (
    .cur_i     (cur_q),
    .req_i     (req_m),
    .tags_ok_i (tags_ok_q),
    .act_o     (act)
  );

  assign start = !sweep_on && !ret_i && req_valid_i && (act == A_INIT);

  cmode_sweep #(.TAGS(TAGS)) sweep_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .active_o (sweep_on),
    .addr_o   (tag_addr_o),
    .done_o   (sweep_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= M_OFF;
      tgt_q     <= M_OFF;
      tags_ok_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (sweep_on) begin
        if (sweep_done) begin
          cur_q     <= tgt_q;
          tags_ok_q <= 1'b1;
        end
      end else if (ret_i) begin
        if (cur_q == M_SPLIT) tags_ok_q <= 1'b0;
        else                  err_q     <= 1'b1;
      end else if (req_valid_i) begin
        unique case (act)
          A_GO:    cur_q <= req_m;
          A_INIT:  tgt_q <= req_m;
          A_ERR:   err_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign mode_o   = cur_q;
  assign busy_o   = sweep_on;
  assign tag_we_o = sweep_on;
  assign err_o    = err_q;

  // R3
  off_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (mode_o == 2'(M_OFF)));

  // R3
  sweep_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_o) && !busy_o) |-> (mode_o == 2'(M_EN) || mode_o == 2'(M_SPLIT)));

  // R6
  err_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (mode_o == $past(mode_o)));

  // R5
  no_err_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> !err_o);
endmodule

// File: tb/cmode_seq_tb_top.sv
module cmode_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TAGS = 6;
  localparam int AW = $clog2(TAGS);
  localparam logic [1:0] OFF = 2'd0, DIS = 2'd1, EN = 2'd2, SPL = 2'd3;
  localparam int NOP = 0, GO = 1, INI = 2, ERR = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, ret = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [1:0] mode;
  logic busy, tag_we, err;
  logic [AW-1:0] tag_addr;

  int total = 0, bad = 0;
  logic [1:0] m_cur = OFF, m_tgt = OFF;
  logic m_ok = 1'b0, m_init = 1'b0, m_err = 1'b0;
  int m_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmode_seq #(.TAGS(TAGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .ret_i(ret), .mode_o(mode), .busy_o(busy), .tag_we_o(tag_we),
    .tag_addr_o(tag_addr), .err_o(err)
  );

  function automatic int rule(logic [1:0] c, logic [1:0] r, logic ok);
    if (r == c) return NOP;
    if (r == OFF) return GO;
    case (c)
      OFF: return (r == DIS) ? GO : INI;
      DIS: return (r == EN && ok) ? GO : ERR;
      EN:  return (r == DIS) ? GO : ERR;
      default: return (r == DIS || (r == EN && ok)) ? GO : ERR;
    endcase
  endfunction

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    m_err = 1'b0;
    if (m_init) begin
      if (m_idx == TAGS - 1) begin m_init = 1'b0; m_cur = m_tgt; m_ok = 1'b1; end
      else m_idx++;
    end else if (ret) begin
      if (m_cur == SPL) m_ok = 1'b0; else m_err = 1'b1;
    end else if (req_valid) begin
      case (rule(m_cur, req_mode, m_ok))
        GO:  m_cur = req_mode;
        INI: begin m_tgt = req_mode; m_init = 1'b1; m_idx = 0; end
        ERR: m_err = 1'b1;
        default: ;
      endcase
    end
  endtask

  task automatic compare();
    chk(mode == (m_init ? OFF : m_cur), "R2 mode", mode, m_init ? OFF : m_cur);
    chk(busy == m_init, "R3 busy", busy, m_init);
    chk(tag_we == m_init, "R4 tag_we", tag_we, m_init);
    if (m_init) chk(int'(tag_addr) == m_idx, "R4 addr", tag_addr, m_idx);
    chk(err == m_err, "R6 err", err, m_err);
  endtask

  task automatic step(input bit v, input logic [1:0] m, input bit r);
    req_valid = v; req_mode = m; ret = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    req_valid = 1'b0; ret = 1'b0;
    compare();
  endtask

  task automatic sweep_to(input logic [1:0] target, input string tag);
    step(1, target, 0);
    chk(busy && mode == OFF && tag_addr == 0, tag, busy, 1);
    for (int i = 1; i < TAGS; i++) begin
      step(1, DIS, (i == 2));
      chk(busy && int'(tag_addr) == i && !err, "R5 ignored in sweep", tag_addr, i);
    end
    step(0, OFF, 0);
    chk(!busy && mode == target, tag, mode, target);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == OFF && !busy && !tag_we && !err, "R1 reset", mode, 0);
    compare();

    step(1, DIS, 0); chk(mode == DIS, "R2 off to dis", mode, DIS);
    step(1, SPL, 0); chk(err && mode == DIS, "R6 dis to split", err, 1);
    step(0, OFF, 0); chk(!err, "R6 err one cycle", err, 0);
    step(1, EN, 0);  chk(err && mode == DIS, "R7 tags invalid", err, 1);
    step(1, OFF, 0); chk(mode == OFF, "R2 to off", mode, OFF);
    sweep_to(EN, "R3 sweep to en");
    step(1, SPL, 0); chk(err && mode == EN, "R6 en to split", err, 1);
    step(1, DIS, 0); chk(mode == DIS, "R2 en to dis", mode, DIS);
    step(1, EN, 0);  chk(mode == EN && !err, "R7 dis to en valid", mode, EN);
    step(0, OFF, 1); chk(err && mode == EN, "R8 retention in en", err, 1);
    step(1, OFF, 0);
    sweep_to(SPL, "R3 sweep to split");
    step(1, EN, 0);  chk(mode == EN && !err, "R7 split to en valid", mode, EN);
    step(1, OFF, 0);
    sweep_to(SPL, "R3 sweep to split again");
    step(0, OFF, 1); chk(mode == SPL && !err, "R8 retention in split", mode, SPL);
    step(1, EN, 0);  chk(err && mode == SPL, "R8 en refused after retention", err, 1);
    step(1, DIS, 1); chk(mode == SPL && !err, "R10 retention wins", mode, SPL);
    step(1, DIS, 0); chk(mode == DIS, "R2 split to dis", mode, DIS);
    step(1, EN, 0);  chk(err && mode == DIS, "R9 still corrupted", err, 1);
    step(1, OFF, 0);
    sweep_to(EN, "R9 recovery sweep");
    step(1, EN, 0);  chk(mode == EN && !err, "R10 same mode", mode, EN);
    step(1, DIS, 0); step(1, EN, 0);
    chk(mode == EN && !err, "R9 tags valid again", mode, EN);

    for (int n = 0; n < 4000; n++) begin
      logic [1:0] rm;
      bit v, r;
      rm = 2'($urandom_range(0, 3));
      v = ($urandom_range(0, 9) < 4);
      r = ($urandom_range(0, 19) == 0);
      step(v, rm, r);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule